// File: doc/BRIEF.md
# External Interrupt Sense and Vectoring Unit

This unit gathers eight active-low external interrupt pins and turns them into a single processor interrupt plus a separate machine-check line. Every pin is first brought into the clock domain. Software then chooses, pin by pin, whether it is recognised while held low or only on a high-to-low transition. Transitions are caught in a latch that software clears by writing ones. Held-low pins are reported for as long as the pin stays low.

Software sees the unit through a small 32-bit register bus with a write strobe and a combinational read path. The registers are a sense selector, a control word, an enable mask, a pending view that is also the clear port, a software force word, and a read-only vector. The vector names the winning enabled source, and 0 means nothing is waiting. Pin 0 can be taken off the ordinary interrupt path and sent to the machine-check line, which software can also silence.

Top module: `extirq_unit`

## Requirements
- R1: After reset the mask, force, sense and control words read 0, the vector reads 0, and `irq_o` and `mcheck_o` are low.
- R2: In the mask, pending and force words (byte offsets 0x08, 0x0C and 0x10), source n sits at bit 31-n, so source 0 is the most significant bit.
- R3: The sense word (offset 0x00) holds the selector of source n at bit 15-n. A 1 selects high-to-low transition sense and a 0 selects held-low sense; other bits read 0.
- R4: In held-low sense, the pending bit of a source is 1 exactly while its synchronised pin is low, and writing a 1 to that bit has no effect.
- R5: In transition sense, a high-to-low pin change sets a pending latch that stays set after the pin returns high. Writing 1 to its bit at offset 0x0C clears it, and writing 0 does not. A transition detected in the same cycle as a clear leaves the latch set.
- R6: `irq_o` goes high only when some pending source has its mask bit at 1. Masked sources remain visible in the pending word.
- R7: The vector word (offset 0x14, bits 6:0) names the lowest-numbered enabled pending source, with code 48 for source 0 and 16+n for sources 1 to 7. It reads 0 when no enabled source is pending.
- R8: A 1 in the force word makes that source pending just as its pin would, under the same mask. Clearing the force bit removes that pending state.
- R9: Control bit 0 (offset 0x04) steers source 0 to `mcheck_o`, regardless of its mask, and removes it from `irq_o` and the vector. Control bit 1 holds `mcheck_o` low.
- R10: `irq_o` and the vector are registered. `irq_o` falls on the clock edge after the last enabled pending source goes away.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pin_n | input | 8 | External interrupt pins, active low, bit n is source n |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Processor interrupt request |
| mcheck_o | output | 1 | Machine-check request |

## Verification
The two functions that can meet in one cycle are a newly detected falling edge and a software write-one-to-clear of the same latch. To provoke it, the bench drives pin 1 low in transition sense and counts the two synchroniser edges. It then places the clear write exactly in the cycle when the edge detector fires, so that both reach the latch on the same clock edge. The pending word is read back afterwards and must still show the source set, and a later clear on its own must empty it.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

    localparam int SRC_N      = 8;
    localparam int DATA_W     = 32;
    localparam int VEC_W      = 7;
    localparam int IRQ0_CODE  = 48;
    localparam int CODE_BASE  = 16;

    // register word selects (byte address / 4)
    localparam int REG_SENSE  = 0;
    localparam int REG_CTRL   = 1;
    localparam int REG_MASK   = 2;
    localparam int REG_PEND   = 3;
    localparam int REG_FORCE  = 4;
    localparam int REG_VEC    = 5;

    typedef struct packed {
        logic [SRC_N-1:0] sense;   // 1 = transition sense
        logic             route;   // source 0 to machine check
        logic             mc_off;  // machine check silenced
        logic [SRC_N-1:0] mask;
        logic [SRC_N-1:0] latch;   // transition latches
        logic [SRC_N-1:0] frc;     // software force
        logic             irq;
        logic             mc;
        logic [VEC_W-1:0] vec;
    } unit_state_t;

    // source n occupies register bit DATA_W-1-n
    function automatic logic [DATA_W-1:0] src_to_reg(input logic [SRC_N-1:0] s);
        logic [DATA_W-1:0] r;
        r = '0;
        for (int n = 0; n < SRC_N; n++) r[DATA_W-1-n] = s[n];
        return r;
    endfunction

    function automatic logic [SRC_N-1:0] reg_to_src(input logic [DATA_W-1:0] r);
        logic [SRC_N-1:0] s;
        for (int n = 0; n < SRC_N; n++) s[n] = r[DATA_W-1-n];
        return s;
    endfunction

    function automatic logic [VEC_W-1:0] vec_code(input int n);
        if (n == 0) return VEC_W'(IRQ0_CODE);
        return VEC_W'(CODE_BASE + n);
    endfunction

endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic active,
    output logic fell
);
    // STAGES synchroniser flops plus one history flop
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], pin_n};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign active = ~chain_q[STAGES-1];
    assign fell   = chain_q[STAGES] & ~chain_q[STAGES-1];

endmodule

// File: rtl/extirq_vecenc.sv
module extirq_vecenc
    import extirq_pkg::*;
(
    input  logic [SRC_N-1:0] req,
    output logic [VEC_W-1:0] code
);
    always_comb begin
        code = '0;
        // scan downward so the lowest-numbered request is kept
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (req[i]) code = vec_code(i);
        end
    end
endmodule

// File: rtl/extirq_unit.sv
module extirq_unit
    import extirq_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int SENSE_MSB   = 15,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  irq_pin_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              mcheck_o
);
    localparam int SEL_W = ADDR_W - 2;

    unit_state_t      st_d, st_q;
    logic [SEL_W-1:0] sel;
    logic [SRC_N-1:0] lvl_act, fell;
    logic [SRC_N-1:0] pend, req, clr;
    logic [VEC_W-1:0] win_code;

    assign sel = bus_addr[ADDR_W-1:2];

    for (genvar g = 0; g < SRC_N; g++) begin : g_pin
        extirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_n  (irq_pin_n[g]),
            .active (lvl_act[g]),
            .fell   (fell[g])
        );
    end

    extirq_vecenc u_enc (
        .req  (req),
        .code (win_code)
    );

    always_comb begin
        for (int n = 0; n < SRC_N; n++) begin
            pend[n] = (st_q.sense[n] ? st_q.latch[n] : lvl_act[n]) | st_q.frc[n];
        end
        req = pend & st_q.mask;
        if (st_q.route) req[0] = 1'b0;
    end

    always_comb begin
        st_d = st_q;
        clr  = '0;
        if (bus_we && sel == SEL_W'(REG_PEND)) clr = reg_to_src(bus_wdata);

        st_d.irq = |req;
        st_d.vec = win_code;
        st_d.mc  = st_q.route & ~st_q.mc_off & pend[0];

        for (int n = 0; n < SRC_N; n++) begin
            // a new edge wins over a clear in the same cycle
            st_d.latch[n] = st_q.sense[n] & ((st_q.latch[n] & ~clr[n]) | fell[n]);
        end

        if (bus_we) begin
            if (sel == SEL_W'(REG_SENSE)) begin
                for (int n = 0; n < SRC_N; n++) st_d.sense[n] = bus_wdata[SENSE_MSB-n];
            end
            if (sel == SEL_W'(REG_CTRL)) begin
                st_d.route  = bus_wdata[0];
                st_d.mc_off = bus_wdata[1];
            end
            if (sel == SEL_W'(REG_MASK))  st_d.mask = reg_to_src(bus_wdata);
            if (sel == SEL_W'(REG_FORCE)) st_d.frc  = reg_to_src(bus_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (sel == SEL_W'(REG_SENSE)) begin
            for (int n = 0; n < SRC_N; n++) bus_rdata[SENSE_MSB-n] = st_q.sense[n];
        end else if (sel == SEL_W'(REG_CTRL)) begin
            bus_rdata[0] = st_q.route;
            bus_rdata[1] = st_q.mc_off;
        end else if (sel == SEL_W'(REG_MASK)) begin
            bus_rdata = src_to_reg(st_q.mask);
        end else if (sel == SEL_W'(REG_PEND)) begin
            bus_rdata = src_to_reg(pend);
        end else if (sel == SEL_W'(REG_FORCE)) begin
            bus_rdata = src_to_reg(st_q.frc);
        end else if (sel == SEL_W'(REG_VEC)) begin
            bus_rdata[VEC_W-1:0] = st_q.vec;
        end
    end

    assign irq_o    = st_q.irq;
    assign mcheck_o = st_q.mc;

    // plain views for the bound checker
    logic [SRC_N-1:0] chk_mask, chk_req;
    logic [VEC_W-1:0] chk_vec;
    logic             chk_route, chk_mc_off;
    assign chk_mask   = st_q.mask;
    assign chk_req    = req;
    assign chk_vec    = st_q.vec;
    assign chk_route  = st_q.route;
    assign chk_mc_off = st_q.mc_off;

endmodule

// File: rtl/extirq_unit_chk.sv
module extirq_unit_chk
    import extirq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             irq_o,
    input logic             mcheck_o,
    input logic [SRC_N-1:0] mask,
    input logic [SRC_N-1:0] req,
    input logic [VEC_W-1:0] vec,
    input logic             route,
    input logic             mc_off
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq_o && !mcheck_o && vec == '0));

    assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |=> !irq_o);

    assert_irq_vec_agree_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (vec != '0));

    assert_vec_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec == '0) || (vec == VEC_W'(IRQ0_CODE)) ||
        (vec > VEC_W'(CODE_BASE) && vec < VEC_W'(CODE_BASE + SRC_N)));

    assert_mc_silenced_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mc_off |=> !mcheck_o);

    assert_route_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        route |=> (vec != VEC_W'(IRQ0_CODE)));

    assert_prompt_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |=> !irq_o);

endmodule

bind extirq_unit extirq_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_o    (irq_o),
    .mcheck_o (mcheck_o),
    .mask     (chk_mask),
    .req      (chk_req),
    .vec      (chk_vec),
    .route    (chk_route),
    .mc_off   (chk_mc_off)
);

// File: tb/extirq_unit_bench.sv
module extirq_unit_bench;
    localparam logic [4:0] A_SENSE = 5'h00, A_CTRL = 5'h04, A_MASK = 5'h08,
                           A_PEND  = 5'h0C, A_FORCE = 5'h10, A_VEC = 5'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  irq_pin_n = 8'hFF;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, mcheck_o;

    int nchk = 0;
    int nfail = 0;

    always #4 clk = ~clk;   // 125 MHz

    extirq_unit u_extirq_unit (
        .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o), .mcheck_o(mcheck_o)
    );

    function automatic logic [31:0] sbit(input int n);
        return 32'h1 << (31 - n);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(A_MASK, v);  chk("R1 mask after reset", v, 0);
        rd(A_FORCE, v); chk("R1 force after reset", v, 0);
        rd(A_SENSE, v); chk("R1 sense after reset", v, 0);
        rd(A_CTRL, v);  chk("R1 ctrl after reset", v, 0);
        rd(A_VEC, v);   chk("R1 vector after reset", v, 0);
        chk("R1 irq after reset", {31'b0, irq_o}, 0);
        chk("R1 mcheck after reset", {31'b0, mcheck_o}, 0);
    endtask

    task automatic t_level;
        logic [31:0] v;
        wr(A_MASK, sbit(3));
        rd(A_MASK, v); chk("R2 mask bit of source 3", v, 32'h1000_0000);
        irq_pin_n[3] = 1'b0;
        idle(5);
        chk("R6 irq with unmasked level source", {31'b0, irq_o}, 1);
        rd(A_VEC, v);  chk("R7 vector source 3", v, 19);
        rd(A_PEND, v); chk("R2 pending bit of source 3", v, 32'h1000_0000);
        wr(A_PEND, sbit(3));
        idle(2);
        rd(A_PEND, v); chk("R4 level ignores clear", v, sbit(3));
        irq_pin_n[5] = 1'b0;
        idle(5);
        rd(A_PEND, v); chk("R6 masked source still pending", v, sbit(3) | sbit(5));
        rd(A_VEC, v);  chk("R6 masked source not vectored", v, 19);
        irq_pin_n[3] = 1'b1;
        idle(5);
        chk("R10 irq falls when source leaves", {31'b0, irq_o}, 0);
        rd(A_VEC, v);  chk("R7 vector zero when none enabled", v, 0);
        irq_pin_n[5] = 1'b1;
        wr(A_MASK, 0);
        idle(4);
    endtask

    task automatic t_priority;
        logic [31:0] v;
        wr(A_MASK, 32'hFF00_0000);
        irq_pin_n[6] = 1'b0; irq_pin_n[2] = 1'b0;
        idle(5);
        rd(A_VEC, v); chk("R7 lowest of 2 and 6", v, 18);
        irq_pin_n[0] = 1'b0;
        idle(5);
        rd(A_VEC, v); chk("R7 source 0 code", v, 48);
        irq_pin_n[0] = 1'b1;
        idle(5);
        rd(A_VEC, v); chk("R7 back to source 2", v, 18);
        irq_pin_n = 8'hFF;
        wr(A_MASK, 0);
        idle(5);
    endtask

    task automatic t_edge;
        logic [31:0] v;
        wr(A_SENSE, 32'h0000_C000);
        rd(A_SENSE, v); chk("R3 sense readback", v, 32'h0000_C000);
        wr(A_MASK, sbit(1));
        irq_pin_n[1] = 1'b0; idle(3); irq_pin_n[1] = 1'b1;
        idle(5);
        rd(A_PEND, v); chk("R5 edge latched after pin release", v, sbit(1));
        chk("R5 irq from latched edge", {31'b0, irq_o}, 1);
        rd(A_VEC, v);  chk("R7 vector source 1", v, 17);
        wr(A_PEND, 0);
        idle(2);
        rd(A_PEND, v); chk("R5 writing zero keeps latch", v, sbit(1));
        wr(A_PEND, sbit(1));
        idle(3);
        rd(A_PEND, v); chk("R5 write one clears latch", v, 0);
        chk("R10 irq low after clear", {31'b0, irq_o}, 0);
        wr(A_MASK, sbit(0));
        irq_pin_n[0] = 1'b0; idle(3); irq_pin_n[0] = 1'b1;
        idle(5);
        rd(A_VEC, v); chk("R3 source 0 edge sense via bit 15", v, 48);
        wr(A_PEND, sbit(0));
        wr(A_MASK, 0);
        idle(3);
    endtask

    task automatic t_collide;
        logic [31:0] v;
        wr(A_SENSE, 32'h0000_4000);
        idle(2);
        @(negedge clk);
        irq_pin_n[1] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = A_PEND; bus_wdata = sbit(1);
        @(negedge clk);
        bus_we = 1'b0;
        irq_pin_n[1] = 1'b1;
        idle(3);
        rd(A_PEND, v); chk("R5 edge wins over same-cycle clear", v, sbit(1));
        wr(A_PEND, sbit(1));
        idle(2);
        rd(A_PEND, v); chk("R5 later clear empties latch", v, 0);
        wr(A_SENSE, 0);
        idle(2);
    endtask

    task automatic t_force;
        logic [31:0] v;
        wr(A_FORCE, sbit(4));
        idle(3);
        rd(A_PEND, v); chk("R8 forced source pending", v, sbit(4));
        chk("R8 forced source masked", {31'b0, irq_o}, 0);
        wr(A_MASK, sbit(4));
        idle(3);
        chk("R8 forced source raises irq", {31'b0, irq_o}, 1);
        rd(A_VEC, v); chk("R8 forced vector", v, 20);
        wr(A_FORCE, 0);
        idle(3);
        chk("R8 irq after force removed", {31'b0, irq_o}, 0);
        wr(A_MASK, 0);
    endtask

    task automatic t_mcheck;
        logic [31:0] v;
        wr(A_CTRL, 32'h1);
        wr(A_MASK, 32'hFF00_0000);
        irq_pin_n[0] = 1'b0;
        idle(5);
        chk("R9 routed source 0 drives mcheck", {31'b0, mcheck_o}, 1);
        chk("R9 routed source 0 off irq", {31'b0, irq_o}, 0);
        rd(A_VEC, v); chk("R9 routed source 0 not vectored", v, 0);
        irq_pin_n[5] = 1'b0;
        idle(5);
        rd(A_VEC, v); chk("R9 other source vectored", v, 21);
        wr(A_CTRL, 32'h3);
        idle(3);
        chk("R9 mcheck silenced", {31'b0, mcheck_o}, 0);
        wr(A_MASK, 0);
        wr(A_CTRL, 32'h1);
        idle(3);
        chk("R9 mcheck ignores mask", {31'b0, mcheck_o}, 1);
        irq_pin_n = 8'hFF;
        wr(A_CTRL, 0);
        idle(5);
        chk("R9 mcheck low when route off", {31'b0, mcheck_o}, 0);
    endtask

    initial begin
        #4_000_000;
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        t_reset;
        t_level;
        t_priority;
        t_edge;
        t_collide;
        t_force;
        t_mcheck;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule